// File: doc/BRIEF.md
# Virtual Address Translator with Direct-Mapped Entry Cache

This block turns a virtual address into a physical address for load, store and instruction-fetch accesses. It first checks that load and store addresses are naturally aligned. It then looks up a direct-mapped cache of page table entries, indexed by the low bits of the virtual page number and tagged with the whole page number. On a miss it asks an external page table walker for the entry and stores a valid result. Finally it checks the access against the entry's user or supervisor permission bits. Each request ends in a one-cycle response that carries either the physical address or a typed fault. The faulting virtual address is held in a register.

Writing the page-table base register aligns the written value to a page and invalidates every cached entry in the same cycle. A request accepted in that same cycle sees an empty cache. The core accepts one request at a time: `reqReady` is low while a walk is outstanding.

Top module: `addrXlate`

## Requirements
- R1: A load or store (`reqKind` 00 or 01) whose address is not a multiple of its size (`reqSize` 0..3 means 1, 2, 4 or 8 bytes) responds in the cycle after acceptance with cause 1 (load) or 2 (store) and starts no walk. A fetch (`reqKind` 10) is never misaligned.
- R2: The entry index is the low log2(ENTRIES) bits of the virtual page number (address bits from 12 up). A lookup hits only if the entry holds the full page number as its tag and its stored PTE has bit 1 set. A different page at the same index displaces the older one.
- R3: On a miss, `walkReq` rises in the cycle after acceptance with `walkVaddr` equal to the request address. Both stay stable until `walkDone`. A walk result with bit 1 clear gives an access fault and is not cached.
- R4: A walk result with bit 1 set is written into the indexed entry. A later access to the same page hits, answers in the cycle after acceptance and issues no walk.
- R5: The required permission bit is 0x040 for a load, 0x020 for a store and 0x010 for a fetch. It is shifted left by 3 when `reqSuper` is high. The access faults when the required bit ANDed with the PTE and 0x3F0 is zero.
- R6: Cause codes are 0 for no fault, 3 for a load access fault, 4 for a store access fault and 5 for a fetch access fault. Each applies to both a failed walk and a failed permission check.
- R7: Every fault loads `badVaddr` with the request address and drives `respPaddr` to zero. `badVaddr` does not change in any other cycle.
- R8: On success, `respPaddr` is the PTE's bits from 12 upward placed at bit 12, with the request's low 12 address bits below them.
- R9: `ptbrWe` loads `ptBase` with `ptbrData` with its low 12 bits cleared. It also invalidates all entries, including for a request accepted in the same cycle.
- R10: `reqReady` is low while a walk is outstanding, and `respValid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Core idle, request accepted this cycle |
| reqAddr | input | ADDR_W | Virtual address |
| reqKind | input | 2 | 00 load, 01 store, 10 fetch |
| reqSize | input | 2 | log2 of access size in bytes |
| reqSuper | input | 1 | Supervisor-mode access |
| respValid | output | 1 | Response strobe |
| respCause | output | 3 | Fault cause code |
| respPaddr | output | PTE_W | Physical address |
| badVaddr | output | ADDR_W | Address of the last fault |
| walkReq | output | 1 | Walk requested |
| walkVaddr | output | ADDR_W | Address to walk |
| walkDone | input | 1 | Walk result valid |
| walkPte | input | PTE_W | Walk result entry |
| ptbrWe | input | 1 | Page-table base write strobe |
| ptbrData | input | ADDR_W | Page-table base write data |
| ptBase | output | ADDR_W | Page-table base register |

## Verification
The bench builds the block with 32-bit addresses and entries and a cache of only 16 entries. With so few entries, random page numbers often collide on an index, so displacement and re-walks happen often. A high page-number bit is flipped at random, so two pages can share an index and differ only in the upper tag bits. The walker's entries depend on the page-table base, so any entry that survives a base write would give a wrong address or permission.

// File: rtl/xlatePkg.sv
package xlatePkg;

  localparam int PAGE_BITS = 12;
  localparam int VALID_BIT = 1;
  localparam logic [9:0] PERM_MASK = 10'h3F0;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10
  } accKindE;

  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_LD_MISALIGN = 3'd1,
    CAUSE_ST_MISALIGN = 3'd2,
    CAUSE_LD_ACCESS  = 3'd3,
    CAUSE_ST_ACCESS  = 3'd4,
    CAUSE_IF_ACCESS  = 3'd5
  } faultCauseE;

  // strobes from control to datapath
  typedef struct packed {
    logic takeLive;   // finish the accepted request this cycle
    logic latchReq;   // hold the request for a walk
    logic takeWalk;   // consume the walk result
  } xlateStrobesT;

  function automatic logic [9:0] needBit(input logic [1:0] kind, input logic sup);
    logic [9:0] b;
    case (kind)
      ACC_STORE: b = 10'h020;
      ACC_FETCH: b = 10'h010;
      default:   b = 10'h040;
    endcase
    return sup ? (b << 3) : b;
  endfunction

  function automatic faultCauseE accessCause(input logic [1:0] kind);
    case (kind)
      ACC_STORE: return CAUSE_ST_ACCESS;
      ACC_FETCH: return CAUSE_IF_ACCESS;
      default:   return CAUSE_LD_ACCESS;
    endcase
  endfunction

endpackage

// File: rtl/xlateEntryArray.sv
module xlateEntryArray #(
  parameter int ENTRIES = 256,
  parameter int VPN_W   = 20,
  parameter int PTE_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [VPN_W-1:0] lookVpn,
  output logic             lookHit,
  output logic [PTE_W-1:0] lookPte,
  input  logic             wrEn,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PTE_W-1:0] wrPte
);
  import xlatePkg::*;

  logic             entValid [ENTRIES];
  logic [VPN_W-1:0] entTag   [ENTRIES];
  logic [PTE_W-1:0] entPte   [ENTRIES];

  logic [IDX_W-1:0] lookIdx;
  logic [IDX_W-1:0] wrIdx;
  logic             wrGo;

  assign lookIdx = lookVpn[IDX_W-1:0];
  assign wrIdx   = wrVpn[IDX_W-1:0];
  assign wrGo    = wrEn && !flush;

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               entValid[e] <= 1'b0;
      else if (flush)                          entValid[e] <= 1'b0;
      else if (wrGo && wrIdx == IDX_W'(e))     entValid[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wrGo && wrIdx == IDX_W'(e)) begin
        entTag[e] <= wrVpn;
        entPte[e] <= wrPte;
      end
    end
  end

  // a flush in the same cycle hides every entry from the lookup
  assign lookPte = entPte[lookIdx];
  assign lookHit = entValid[lookIdx] && !flush &&
                   lookPte[VALID_BIT] && (entTag[lookIdx] == lookVpn);

endmodule

// File: rtl/xlateDatapath.sv
module xlateDatapath #(
  parameter int ADDR_W  = 32,
  parameter int PTE_W   = 32,
  parameter int ENTRIES = 256,
  localparam int VPN_W  = ADDR_W - xlatePkg::PAGE_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xlatePkg::xlateStrobesT strobes,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqKind,
  input  logic [1:0]            reqSize,
  input  logic                  reqSuper,
  input  logic [PTE_W-1:0]      walkPte,
  input  logic                  ptbrWe,
  input  logic [ADDR_W-1:0]     ptbrData,
  output logic                  misalign,
  output logic                  hit,
  output logic [ADDR_W-1:0]     walkVaddr,
  output logic                  respValid,
  output logic [2:0]            respCause,
  output logic [PTE_W-1:0]      respPaddr,
  output logic [ADDR_W-1:0]     badVaddr,
  output logic [ADDR_W-1:0]     ptBase
);
  import xlatePkg::*;

  logic [ADDR_W-1:0] heldAddr;
  logic [1:0]        heldKind;
  logic              heldSuper;
  logic [2:0]        lowMask;
  logic [PTE_W-1:0]  hitPte;
  logic              livePermOk;
  logic              walkPermOk;
  logic              walkValid;
  logic              refill;

  always_comb begin
    case (reqSize)
      2'd0:    lowMask = 3'b000;
      2'd1:    lowMask = 3'b001;
      2'd2:    lowMask = 3'b011;
      default: lowMask = 3'b111;
    endcase
  end

  assign misalign = (reqKind != ACC_FETCH) && (|(reqAddr[2:0] & lowMask));

  assign walkValid  = walkPte[VALID_BIT];
  assign refill     = strobes.takeWalk && walkValid;
  assign livePermOk = |(needBit(reqKind, reqSuper) & hitPte[9:0] & PERM_MASK);
  assign walkPermOk = |(needBit(heldKind, heldSuper) & walkPte[9:0] & PERM_MASK);

  xlateEntryArray #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PTE_W   (PTE_W)
  ) u_entries (
    .clk     (clk),
    .rstN    (rstN),
    .flush   (ptbrWe),
    .lookVpn (reqAddr[ADDR_W-1:PAGE_BITS]),
    .lookHit (hit),
    .lookPte (hitPte),
    .wrEn    (refill),
    .wrVpn   (heldAddr[ADDR_W-1:PAGE_BITS]),
    .wrPte   (walkPte)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr  <= '0;
      heldKind  <= ACC_LOAD;
      heldSuper <= 1'b0;
    end else if (strobes.latchReq) begin
      heldAddr  <= reqAddr;
      heldKind  <= reqKind;
      heldSuper <= reqSuper;
    end
  end

  assign walkVaddr = heldAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respCause <= CAUSE_NONE;
      respPaddr <= '0;
      badVaddr  <= '0;
    end else begin
      respValid <= strobes.takeLive || strobes.takeWalk;
      if (strobes.takeLive) begin
        if (misalign) begin
          respCause <= (reqKind == ACC_STORE) ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
          respPaddr <= '0;
          badVaddr  <= reqAddr;
        end else if (livePermOk) begin
          respCause <= CAUSE_NONE;
          respPaddr <= {hitPte[PTE_W-1:PAGE_BITS], reqAddr[PAGE_BITS-1:0]};
        end else begin
          respCause <= accessCause(reqKind);
          respPaddr <= '0;
          badVaddr  <= reqAddr;
        end
      end else if (strobes.takeWalk) begin
        if (walkValid && walkPermOk) begin
          respCause <= CAUSE_NONE;
          respPaddr <= {walkPte[PTE_W-1:PAGE_BITS], heldAddr[PAGE_BITS-1:0]};
        end else begin
          respCause <= accessCause(heldKind);
          respPaddr <= '0;
          badVaddr  <= heldAddr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ptBase <= '0;
    else if (ptbrWe) ptBase <= {ptbrData[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  end

endmodule

// File: rtl/xlateCtrl.sv
module xlateCtrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   misalign,
  input  logic                   hit,
  input  logic                   walkDone,
  output logic                   reqReady,
  output logic                   walkReq,
  output xlatePkg::xlateStrobesT strobes
);
  import xlatePkg::*;

  typedef enum logic {ST_IDLE, ST_WALK} ctrlStateE;
  ctrlStateE state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (misalign || hit) begin
            strobes.takeLive = 1'b1;
          end else begin
            strobes.latchReq = 1'b1;
            stateNext        = ST_WALK;
          end
        end
      end
      default: begin
        if (walkDone) begin
          strobes.takeWalk = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign walkReq  = (state == ST_WALK);

endmodule

// File: rtl/addrXlate.sv
module addrXlate #(
  parameter int ADDR_W  = 32,
  parameter int PTE_W   = 32,
  parameter int ENTRIES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqSize,
  input  logic              reqSuper,
  output logic              respValid,
  output logic [2:0]        respCause,
  output logic [PTE_W-1:0]  respPaddr,
  output logic [ADDR_W-1:0] badVaddr,
  output logic              walkReq,
  output logic [ADDR_W-1:0] walkVaddr,
  input  logic              walkDone,
  input  logic [PTE_W-1:0]  walkPte,
  input  logic              ptbrWe,
  input  logic [ADDR_W-1:0] ptbrData,
  output logic [ADDR_W-1:0] ptBase
);
  import xlatePkg::*;

  xlateStrobesT strobes;
  logic         misalign;
  logic         hit;

  xlateCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .misalign (misalign),
    .hit      (hit),
    .walkDone (walkDone),
    .reqReady (reqReady),
    .walkReq  (walkReq),
    .strobes  (strobes)
  );

  xlateDatapath #(
    .ADDR_W  (ADDR_W),
    .PTE_W   (PTE_W),
    .ENTRIES (ENTRIES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .reqKind   (reqKind),
    .reqSize   (reqSize),
    .reqSuper  (reqSuper),
    .walkPte   (walkPte),
    .ptbrWe    (ptbrWe),
    .ptbrData  (ptbrData),
    .misalign  (misalign),
    .hit       (hit),
    .walkVaddr (walkVaddr),
    .respValid (respValid),
    .respCause (respCause),
    .respPaddr (respPaddr),
    .badVaddr  (badVaddr),
    .ptBase    (ptBase)
  );

endmodule

// File: rtl/addrXlateChk.sv
module addrXlateChk #(
  parameter int ADDR_W  = 32,
  parameter int PTE_W   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqKind,
  input logic [1:0]        reqSize,
  input logic              reqSuper,
  input logic              respValid,
  input logic [2:0]        respCause,
  input logic [PTE_W-1:0]  respPaddr,
  input logic [ADDR_W-1:0] badVaddr,
  input logic              walkReq,
  input logic [ADDR_W-1:0] walkVaddr,
  input logic              walkDone,
  input logic [PTE_W-1:0]  walkPte,
  input logic              ptbrWe,
  input logic [ADDR_W-1:0] ptbrData,
  input logic [ADDR_W-1:0] ptBase
);

  // R1
  ld_half_misalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqKind == 2'b00 && reqSize == 2'd1 && reqAddr[0]
    |=> respValid && respCause == 3'd1);

  // R1
  st_misalign_nowalk_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqKind == 2'b01 && reqSize != 2'd0 && reqAddr[0]
    |=> !walkReq && respCause == 3'd2);

  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && !walkDone |=> walkReq && $stable(walkVaddr));

  // R3
  bad_walk_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && walkDone && !walkPte[1]
    |=> respValid && respCause != 3'd0 && badVaddr == $past(walkVaddr));

  // R8
  walk_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && walkDone
    |=> respValid && (respCause != 3'd0 || respPaddr[11:0] == $past(walkVaddr[11:0])));

  // R7
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respCause != 3'd0 |-> respPaddr == '0);

  // R7
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(respValid && respCause != 3'd0) |-> $stable(badVaddr));

  // R9
  base_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptbrWe |=> ptBase[11:0] == 12'd0 && ptBase[ADDR_W-1:12] == $past(ptbrData[ADDR_W-1:12]));

  // R9
  flush_forces_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && ptbrWe && reqKind == 2'b10 |=> walkReq);

endmodule

bind addrXlate addrXlateChk #(.ADDR_W(ADDR_W), .PTE_W(PTE_W)) u_chk (.*);

// File: tb/addrXlate_tb.sv
module addrXlate_tb;
  localparam int AW = 32;
  localparam int PW = 32;
  localparam int NENT = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqKind = '0;
  logic [1:0]    reqSize = '0;
  logic          reqSuper = 1'b0;
  logic          respValid;
  logic [2:0]    respCause;
  logic [PW-1:0] respPaddr;
  logic [AW-1:0] badVaddr;
  logic          walkReq;
  logic [AW-1:0] walkVaddr;
  logic          walkDone = 1'b0;
  logic [PW-1:0] walkPte = '0;
  logic          ptbrWe = 1'b0;
  logic [AW-1:0] ptbrData = '0;
  logic [AW-1:0] ptBase;

  int checks = 0;
  int fails = 0;

  logic          mValid [NENT];
  logic [19:0]   mTag   [NENT];
  logic [31:0]   mPte   [NENT];
  logic [31:0]   mBase = '0;
  logic [31:0]   mBad  = '0;

  addrXlate #(.ADDR_W(AW), .PTE_W(PW), .ENTRIES(NENT)) u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pteModel(input logic [19:0] vpn, input logic [31:0] base);
    logic [31:0] h;
    h = {12'd0, vpn} * 32'h2545F491 + base;
    h = h ^ (h >> 15);
    h = h * 32'h0019660D;
    h = h ^ (h >> 11);
    return {h[31:12], 2'b00, h[27:22], 2'b00, (h[3:0] != 4'd0), 1'b0};
  endfunction

  function automatic bit permPass(input logic [1:0] kind, input logic sup, input logic [31:0] pte);
    logic [9:0] need;
    need = (kind == 2'b01) ? 10'h020 : (kind == 2'b10) ? 10'h010 : 10'h040;
    if (sup) need = need << 3;
    return (need & pte[9:0] & 10'h3F0) != 10'd0;
  endfunction

  function automatic logic [2:0] accCause(input logic [1:0] kind);
    return (kind == 2'b01) ? 3'd4 : (kind == 2'b10) ? 3'd5 : 3'd3;
  endfunction

  task automatic modelFlush(input logic [31:0] data);
    for (int i = 0; i < NENT; i++) mValid[i] = 1'b0;
    mBase = {data[31:12], 12'd0};
  endtask

  // entered and left at a falling edge
  task automatic writeBase(input logic [31:0] data);
    ptbrWe = 1'b1; ptbrData = data;
    @(negedge clk);
    ptbrWe = 1'b0;
    modelFlush(data);
    chk(ptBase == {data[31:12], 12'd0}, "R9 base", ptBase, {data[31:12], 12'd0});
  endtask

  task automatic doAccess(input logic [31:0] addr, input logic [1:0] kind, input logic [1:0] size,
                          input logic sup, input bit flushNow, input logic [31:0] flushData);
    bit          mis, expWalk, sawWalk, ok;
    logic [2:0]  expCause;
    logic [31:0] expPa, pte, lowMask;
    logic [19:0] vpn;
    int          idx, delay;
    string       tagW, tagC;

    if (flushNow) modelFlush(flushData);
    lowMask = (32'd1 << size) - 32'd1;
    mis = (kind != 2'b10) && ((addr & lowMask) != 0);
    vpn = addr[31:12];
    idx = int'(vpn % NENT);
    expWalk = 1'b0; pte = '0;
    if (mis) begin
      expCause = (kind == 2'b01) ? 3'd2 : 3'd1;
      tagC = "R1";
    end else begin
      if (mValid[idx] && mTag[idx] == vpn) begin
        pte = mPte[idx];
      end else begin
        expWalk = 1'b1;
        pte = pteModel(vpn, mBase);
      end
      if (!pte[1]) begin
        expCause = accCause(kind);
        tagC = "R3";
      end else begin
        if (expWalk) begin
          mValid[idx] = 1'b1; mTag[idx] = vpn; mPte[idx] = pte;
        end
        ok = permPass(kind, sup, pte);
        expCause = ok ? 3'd0 : accCause(kind);
        tagC = ok ? "R8" : "R5";
      end
    end
    expPa = (expCause == 3'd0) ? {pte[31:12], addr[11:0]} : 32'd0;
    if (expCause != 3'd0) mBad = addr;
    tagW = expWalk ? "R2" : "R4";

    reqValid = 1'b1; reqAddr = addr; reqKind = kind; reqSize = size; reqSuper = sup;
    ptbrWe = flushNow; ptbrData = flushData;
    @(negedge clk);
    reqValid = 1'b0; ptbrWe = 1'b0;
    sawWalk = 1'b0;
    delay = int'($urandom % 3);
    for (int c = 0; c < 40 && !respValid; c++) begin
      if (walkReq) begin
        if (!sawWalk) begin
          chk(walkVaddr == addr, "R3 walk address", walkVaddr, addr);
          chk(!reqReady, "R10 busy", reqReady, 0);
        end
        sawWalk = 1'b1;
        if (delay == 0) begin
          walkDone = 1'b1; walkPte = pteModel(vpn, mBase);
        end else begin
          delay--;
        end
      end
      @(negedge clk);
    end
    walkDone = 1'b0;
    chk(respValid, "R10 response", respValid, 1);
    chk(sawWalk == expWalk, tagW, sawWalk, expWalk);
    chk(respCause == expCause, (expCause >= 3'd3) ? "R6" : tagC, respCause, expCause);
    chk(respPaddr == expPa, tagC, respPaddr, expPa);
    chk(badVaddr == mBad, "R7", badVaddr, mBad);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    chk(!respValid, "R10 single pulse", respValid, 0);
    chk(badVaddr == mBad, "R7 hold", badVaddr, mBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [19:0] vpn;
    logic [31:0] addr;
    logic [1:0]  kind, size;
    void'($urandom(32'd4242));
    for (int i = 0; i < NENT; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R10 reset ready", reqReady, 1);
    chk(respValid == 1'b0, "R10 reset resp", respValid, 0);
    chk(walkReq == 1'b0, "R3 reset walk", walkReq, 0);
    chk(badVaddr == '0, "R7 reset bad", badVaddr, 0);
    chk(ptBase == '0, "R9 reset base", ptBase, 0);
    rstN = 1'b1;
    @(negedge clk);

    writeBase(32'h0001_2ABC);
    // R1 misaligned half load, word store; odd fetch is fine
    doAccess(32'h0000_1001, 2'b00, 2'd1, 1'b0, 1'b0, '0);
    doAccess(32'h0000_2002, 2'b01, 2'd2, 1'b0, 1'b0, '0);
    doAccess(32'h0000_3003, 2'b10, 2'd3, 1'b0, 1'b0, '0);
    doAccess(32'h0000_2006, 2'b01, 2'd3, 1'b1, 1'b0, '0);
    idleCheck();
    // R4 refill then hit, several kinds and modes on one page
    for (int j = 0; j < 8; j++)
      doAccess(32'h0000_5000 + 32'(j * 8), 2'(j % 3), 2'd3, 1'(j / 4), 1'b0, '0);
    // R2 alias at the same index, then back
    doAccess(32'h0001_5010, 2'b00, 2'd0, 1'b0, 1'b0, '0);
    doAccess(32'h8000_5010, 2'b00, 2'd0, 1'b0, 1'b0, '0);
    doAccess(32'h0000_5010, 2'b00, 2'd0, 1'b0, 1'b0, '0);
    // R9 flush in the same cycle as a lookup of a cached page
    doAccess(32'h0000_5020, 2'b10, 2'd0, 1'b1, 1'b1, 32'h0004_0FFF);
    doAccess(32'h0000_5024, 2'b10, 2'd0, 1'b1, 1'b0, '0);
    idleCheck();

    for (int n = 0; n < 700; n++) begin
      vpn  = 20'($urandom % 40) ^ (($urandom % 2) != 0 ? 20'h80000 : 20'h0);
      kind = 2'($urandom % 3);
      size = 2'($urandom % 4);
      addr = {vpn, 12'($urandom % 4096)};
      if ($urandom % 3 != 0) addr = addr & ~((32'd1 << size) - 32'd1);
      if ($urandom % 50 == 0) writeBase($urandom);
      doAccess(addr, kind, size, 1'($urandom % 2), ($urandom % 60) == 0, $urandom);
      if ($urandom % 10 == 0) idleCheck();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule